// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives on a pin with no timing relation to the memory clock. The block brings that pin into the clock domain through a flop chain. It then walks a four-state machine through a timed entry phase, the sleep phase and a timed recovery phase.

The block has three state outputs: asleep, recovering and access-permitted. These outputs gate the chip-select and address-strobe paths of the surrounding memory controller. Select and strobe requests pass through the block and are forwarded only while access is permitted. A request seen while access is closed is dropped and sets a sticky protocol-violation flag. If an access is still pending when the entry phase begins, a one-cycle abort pulse marks that access as invalid.

Reset is synchronous and active high. All outputs are registered.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: During reset and just after it, the outputs are as follows: access_ok_o is 1, and asleep_o, recovering_o, sel_go_o, strobe_go_o, abort_o and viol_o are all 0.
- R2: The sleep request passes through a two-flop synchronizer. If the request rises before clock edge 1, access_ok_o falls after clock edge 3.
- R3: The entry phase lasts exactly two cycles. During those cycles access_ok_o, asleep_o and recovering_o are all 0. After that, asleep_o rises.
- R4: asleep_o stays at 1 for as long as the synchronized request stays high.
- R5: If the request falls before clock edge 1, asleep_o falls after clock edge 3. recovering_o then stays at 1 for exactly two cycles, and after that access_ok_o returns to 1.
- R6: While access_ok_o is 1, sel_go_o and strobe_go_o copy sel_i and strobe_i with a delay of one cycle.
- R7: While access_ok_o is 0, a select or strobe is not forwarded, and sel_go_o and strobe_go_o stay at 0.
- R8: If a select or strobe is seen while access_ok_o is 0, viol_o goes to 1 one cycle later. viol_o then stays at 1 until reset.
- R9: abort_o pulses for exactly one cycle, in the first cycle of the entry phase, when pend_i was high on the edge that started entry. If pend_i was low on that edge, abort_o stays at 0.
- R10: A request that rises again during recovery does not cut recovery short. Recovery runs its full length, access_ok_o is 1 for one cycle, and then a new entry phase starts.
- R11: A request that falls during the entry phase does not abort entry. Entry completes to asleep for one cycle, and then recovery follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req_i | input | 1 | Sleep request, asynchronous to clk |
| sel_i | input | 1 | Chip-select request from the controller |
| strobe_i | input | 1 | Address-strobe request from the controller |
| pend_i | input | 1 | An access is in flight |
| access_ok_o | output | 1 | Accesses are permitted (awake state) |
| asleep_o | output | 1 | Memory is in sleep |
| recovering_o | output | 1 | Recovery window after wake |
| sel_go_o | output | 1 | Forwarded chip select |
| strobe_go_o | output | 1 | Forwarded address strobe |
| abort_o | output | 1 | One-cycle pulse: pending access invalidated |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, two entry cycles and two exit cycles. With these values every phase boundary falls at a fixed, known negedge after a request edge, so the exact cycles of R2, R3 and R5 can be compared against hand-counted expectations. The short windows also make the overlap cases easy to reach: a request that rises again within the two recovery cycles (R10), and one that falls within the two entry cycles (R11).

// File: rtl/mem_sleep_pkg.sv
package mem_sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_t;
endpackage

// File: rtl/sleep_sync.sv
// Flop chain that moves the asynchronous sleep request into the clock domain.
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
// Four-state sequencer with timed entry and recovery phases.
module sleep_fsm
  import mem_sleep_pkg::*;
#(
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic entry_start_o,
  output logic access_ok_o,
  output logic asleep_o,
  output logic recovering_o
);
  localparam int MAXC  = (ENTER_CYCLES > EXIT_CYCLES) ? ENTER_CYCLES : EXIT_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] ENT_LOAD = CNT_W'(ENTER_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXT_LOAD = CNT_W'(EXIT_CYCLES - 1);

  slp_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        if (req_i) begin
          state_d = ST_ENTER;
          cnt_d   = ENT_LOAD;
        end
      end
      ST_ENTER: begin
        if (cnt_q == '0) state_d = ST_ASLEEP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_ASLEEP: begin
        if (!req_i) begin
          state_d = ST_RECOVER;
          cnt_d   = EXT_LOAD;
        end
      end
      ST_RECOVER: begin
        if (cnt_q == '0) state_d = ST_AWAKE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  assign entry_start_o = (state_q == ST_AWAKE) && req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_AWAKE;
      cnt_q        <= '0;
      access_ok_o  <= 1'b1;
      asleep_o     <= 1'b0;
      recovering_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      access_ok_o  <= (state_d == ST_AWAKE);
      asleep_o     <= (state_d == ST_ASLEEP);
      recovering_o <= (state_d == ST_RECOVER);
    end
  end

  // Window counters that measure phase lengths from the outputs alone.
  logic [CNT_W:0] ent_run_q, rec_run_q;
  logic           entering_seen;
  assign entering_seen = !access_ok_o && !asleep_o && !recovering_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_run_q <= '0;
      rec_run_q <= '0;
    end else begin
      ent_run_q <= entering_seen ? ent_run_q + 1'b1 : '0;
      rec_run_q <= recovering_o  ? rec_run_q + 1'b1 : '0;
    end
  end

  assert_entry_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep_o) |-> (ent_run_q == (CNT_W+1)'(ENTER_CYCLES)));

  assert_recover_len_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(access_ok_o) |-> (rec_run_q == (CNT_W+1)'(EXIT_CYCLES)));

  assert_wake_via_recover_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep_o) |-> recovering_o);

  assert_hold_asleep_R4: assert property (@(posedge clk) disable iff (rst)
    (asleep_o && $past(asleep_o) && req_i) |=> asleep_o);
endmodule

// File: rtl/access_guard.sv
// Forwards select/strobe lines only while permitted; flags misuse and aborts.
module access_guard #(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ok_i,
  input  logic               entry_start_i,
  input  logic               pend_i,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] go_o,
  output logic               abort_o,
  output logic               viol_o
);
  genvar gi;
  generate
    for (gi = 0; gi < N_LINES; gi++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) go_o[gi] <= 1'b0;
        else     go_o[gi] <= line_i[gi] & ok_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_o <= 1'b0;
      viol_o  <= 1'b0;
    end else begin
      abort_o <= entry_start_i & pend_i;
      viol_o  <= viol_o | (!ok_i & (|line_i));
    end
  end

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> viol_o);

  assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);

  assert_abort_closes_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !ok_i);

  assert_fwd_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (|go_o) |-> $past(ok_i));
endmodule

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req_i,
  input  logic sel_i,
  input  logic strobe_i,
  input  logic pend_i,
  output logic access_ok_o,
  output logic asleep_o,
  output logic recovering_o,
  output logic sel_go_o,
  output logic strobe_go_o,
  output logic abort_o,
  output logic viol_o
);
  localparam int N_LINES = 2;

  logic               req_sync;
  logic               entry_start;
  logic [N_LINES-1:0] lines, go;

  assign lines = {strobe_i, sel_i};

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sleep_req_i),
    .q_o (req_sync)
  );

  sleep_fsm #(.ENTER_CYCLES(ENTER_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_sync),
    .entry_start_o (entry_start),
    .access_ok_o   (access_ok_o),
    .asleep_o      (asleep_o),
    .recovering_o  (recovering_o)
  );

  access_guard #(.N_LINES(N_LINES)) u_guard (
    .clk           (clk),
    .rst           (rst),
    .ok_i          (access_ok_o),
    .entry_start_i (entry_start),
    .pend_i        (pend_i),
    .line_i        (lines),
    .go_o          (go),
    .abort_o       (abort_o),
    .viol_o        (viol_o)
  );

  assign sel_go_o    = go[0];
  assign strobe_go_o = go[1];

  assert_states_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({access_ok_o, asleep_o, recovering_o}));
endmodule

// File: tb/mem_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module mem_sleep_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, sel = 1'b0, stb = 1'b0, pend = 1'b0;
  logic ok, asl, rec, sgo, tgo, abt, vio;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  mem_sleep_ctrl u_dut (
    .clk(clk), .rst(rst), .sleep_req_i(req), .sel_i(sel), .strobe_i(stb),
    .pend_i(pend), .access_ok_o(ok), .asleep_o(asl), .recovering_o(rec),
    .sel_go_o(sgo), .strobe_go_o(tgo), .abort_o(abt), .viol_o(vio)
  );

  // Row: [10:7] = {req, sel, strobe, pend} driven after the check;
  //      [6:0]  = expected {ok, asleep, recovering, sel_go, strobe_go, abort, viol}.
  localparam logic [10:0] VEC [0:15] = '{
    11'b0100_1000000, 11'b0010_1001000, 11'b1001_1000100, 11'b1001_1000000,
    11'b1001_1000000, 11'b1000_0000010, 11'b1100_0000000, 11'b1000_0100001,
    11'b0000_0100001, 11'b0000_0100001, 11'b0000_0100001, 11'b0010_0010001,
    11'b0000_0010001, 11'b0100_1000001, 11'b0000_1001001, 11'b0000_1000001
  };

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 access_ok", ok, 1'b1);
    chk("R1 asleep", asl, 1'b0);
    chk("R1 viol", vio, 1'b0);
    rst = 1'b0;

    // Table walk: main sequence with abort, violation and blocking.
    for (int i = 0; i < 16; i++) begin
      if (i > 0) cyc(1);
      chk("R2 R5 access_ok", ok,  VEC[i][6]);
      chk("R3 R4 asleep",    asl, VEC[i][5]);
      chk("R5 recovering",   rec, VEC[i][4]);
      chk("R6 R7 sel_go",    sgo, VEC[i][3]);
      chk("R6 R7 strobe_go", tgo, VEC[i][2]);
      chk("R9 abort",        abt, VEC[i][1]);
      chk("R8 viol",         vio, VEC[i][0]);
      {req, sel, stb, pend} = VEC[i][10:7];
    end

    // Reset clears the sticky flag (R1, R8).
    cyc(1);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    chk("R1 R8 viol cleared", vio, 1'b0);
    chk("R1 access_ok", ok, 1'b1);
    chk("R1 recovering", rec, 1'b0);

    // R9: no abort without a pending access.
    req = 1'b1; pend = 1'b0;
    cyc(3);
    chk("R2 access_ok closed", ok, 1'b0);
    chk("R9 no abort", abt, 1'b0);
    cyc(2);
    chk("R3 asleep", asl, 1'b1);

    // R10: request returns during recovery.
    req = 1'b0;
    cyc(3);
    chk("R10 recovering", rec, 1'b1);
    req = 1'b1;
    cyc(1);
    chk("R10 still recovering", rec, 1'b1);
    cyc(1);
    chk("R10 awake one cycle", ok, 1'b1);
    cyc(1);
    chk("R10 re-entry", ok, 1'b0);
    chk("R10 re-entry not asleep", asl, 1'b0);
    cyc(2);
    chk("R10 asleep again", asl, 1'b1);

    // R11: request drops during entry.
    req = 1'b0;
    cyc(5);
    chk("R5 awake", ok, 1'b1);
    req = 1'b1;
    cyc(3);
    chk("R11 entering", ok, 1'b0);
    req = 1'b0;
    cyc(2);
    chk("R11 asleep reached", asl, 1'b1);
    cyc(1);
    chk("R11 recovering", rec, 1'b1);
    chk("R11 asleep left", asl, 1'b0);
    cyc(2);
    chk("R11 awake", ok, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule